// File: doc/BRIEF.md
# Sampling Clock Prescaler Controller

This block paces a supply-voltage monitor. It divides a free-running input clock by a power of two, from 2 to 65536. At each wrap of the divider it issues a one-cycle sample strobe. From the operating mode and the standby state it derives the enable line of the monitor. In continuous mode the monitor stays enabled for as long as the sampling clock runs. In sampled mode the monitor is enabled only in strobe cycles.

A 16-bit control word is written and read through a plain register port. The clock-enable position does not return the written request. It returns a run status that follows the request after a two-cycle synchronisation delay, both when the clock starts and when it stops. The port has no data stream, so there is no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high, and `rd_data` always shows the current view of the register.

Top module: `smpclk_ctrl`

## Requirements
- R1: With prescaler select N (field bits 15:12), the divider period is D = 2^(N+1) input cycles. Code 0 gives 2 and code 15 gives 65536. While the clock runs, `sample_strobe` is high for one cycle in every D cycles.
- R2: Writing 1 to the clock-enable bit (bit 9) starts the sampling clock. Writing 0 stops it. Once the run status reads 0, no further strobe appears.
- R3: Bit 9 of `rd_data` reads the run status, not the written request. After the write edge it stays at its old value for that cycle and the next one, and shows the new value from the second cycle after the write. This holds for both start and stop.
- R4: Mode bit 8 = 0 selects continuous operation, where `monitor_en` is high for the whole time the clock runs. Mode bit 8 = 1 selects sampled operation, where `monitor_en` is high only in the cycles where `sample_strobe` is high.
- R5: Run-in-standby is bit 6. When `standby` is high and bit 6 is 0, both `monitor_en` and `sample_strobe` are low. When bit 6 is 1, standby has no effect.
- R6: Bits 6, 8 and 15:12 read back the written values. Bits 11, 10, 7 and 5:0 always read 0, and writes to them have no effect.
- R7: A write that changes the prescaler select restarts the divider at that write edge. The next strobe appears in cycle p + D_new - 1, where p is the write edge. This is so even if the old divider was due to wrap at the same edge.
- R8: A synchronous active-high reset clears every field. After reset `rd_data` = 0 (divide by 2, continuous mode, clock stopped), and neither `sample_strobe` nor `monitor_en` is active.
- R9: After a start write at edge w from a stopped state, the first strobe appears in cycle w + 1 + D. The strobes that follow come every D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| standby | input | 1 | High while the system is in standby |
| rd_data | output | 16 | Register view, with the run status in bit 9 |
| sample_strobe | output | 1 | One-cycle pulse at each divider wrap |
| monitor_en | output | 1 | Enable line to the voltage monitor |

## Verification
Two events can fall on the same edge: a prescaler-select write that clears the divider, and the divider's own wrap. The bench forces this collision by writing a new select at the edge that follows a strobe cycle of a divide-by-4 run. It then requires that the next strobe arrives one new period, minus one cycle, after that write, with no extra pulse and no pulse at the old spacing. A second overlap comes when standby is raised while strobes are running. It is judged by checking that both outputs stay low in those cycles unless the run-in-standby bit is set.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;
  localparam int REG_W    = 16;
  localparam int PSEL_W   = 4;
  localparam int PSEL_LSB = 12;
  localparam int RSB_BIT  = 6;
  localparam int MODE_BIT = 8;
  localparam int CEN_BIT  = 9;

  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic              cen_req;
    logic              mode;
    logic              rsb;
  } ctrl_t;

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[PSEL_LSB +: PSEL_W] = '1;
    m[RSB_BIT]  = 1'b1;
    m[MODE_BIT] = 1'b1;
    m[CEN_BIT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/smpclk_regs.sv
module smpclk_regs
  import smpclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             status,
  output ctrl_t            ctrl,
  output logic             psel_chg,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] RSV_MASK = ~live_mask();

  logic unused_bits;
  assign unused_bits = ^(wr_data & RSV_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.psel    <= wr_data[PSEL_LSB +: PSEL_W];
      ctrl.cen_req <= wr_data[CEN_BIT];
      ctrl.mode    <= wr_data[MODE_BIT];
      ctrl.rsb     <= wr_data[RSB_BIT];
    end
  end

  assign psel_chg = wr_en && (wr_data[PSEL_LSB +: PSEL_W] != ctrl.psel);

  always_comb begin
    rd_data = '0;
    rd_data[PSEL_LSB +: PSEL_W] = ctrl.psel;
    rd_data[CEN_BIT]  = status;
    rd_data[MODE_BIT] = ctrl.mode;
    rd_data[RSB_BIT]  = ctrl.rsb;
  end

  // R6: reserved positions never show a one
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSV_MASK) == '0);
endmodule

// File: rtl/smpclk_sync.sv
module smpclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic status
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], req};
  end

  assign status = pipe[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
      end
      // R3: status repeats the request seen two edges earlier
      p_status_lag_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (status == $past(req, 2)));
    end
  endgenerate
endmodule

// File: rtl/smpclk_prescaler.sv
module smpclk_prescaler #(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clr,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int CNT_W = 1 << PSEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = ~({CNT_W{1'b1}} << (int'(psel) + 1));
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || clr) cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R1: a strobe never lasts two cycles
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R2: a stopped divider sits at zero
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/smpclk_ctrl.sv
module smpclk_ctrl
  import smpclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             standby,
  output logic [REG_W-1:0] rd_data,
  output logic             sample_strobe,
  output logic             monitor_en
);
  ctrl_t ctrl;
  logic  psel_chg;
  logic  running;
  logic  tick;
  logic  stby_ok;

  smpclk_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .status(running), .ctrl(ctrl), .psel_chg(psel_chg), .rd_data(rd_data)
  );

  smpclk_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .req(ctrl.cen_req), .status(running)
  );

  smpclk_prescaler #(.PSEL_W(PSEL_W)) u_div (
    .clk(clk), .rst(rst), .run(running), .clr(psel_chg),
    .psel(ctrl.psel), .tick(tick)
  );

  assign stby_ok       = !standby || ctrl.rsb;
  assign sample_strobe = tick && stby_ok;
  assign monitor_en    = running && (!ctrl.mode || tick) && stby_ok;

  // R5: standby without permission silences both outputs
  p_standby_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (standby && !rd_data[RSB_BIT]) |-> (!monitor_en && !sample_strobe));
  // R4: sampled mode enables the monitor only on a strobe
  p_sampled_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data[MODE_BIT] && monitor_en) |-> sample_strobe);
  // R4: continuous mode holds the enable while running
  p_cont_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data[CEN_BIT] && !rd_data[MODE_BIT] && !standby) |-> monitor_en);
endmodule

// File: tb/tb_smpclk_ctrl.sv
module tb_smpclk_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        standby = 1'b0;
  logic [15:0] rd_data;
  logic        sample_strobe;
  logic        monitor_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  int exp_q[$];

  smpclk_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .standby(standby), .rd_data(rd_data),
    .sample_strobe(sample_strobe), .monitor_en(monitor_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // monitor: pops expected strobe cycles as strobes appear
  always @(negedge clk) begin : mon
    int e;
    if (mon_on && sample_strobe) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 unexpected strobe actual=%0d expected=none", cyc);
      end else begin
        e = exp_q.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL R1 strobe cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  task automatic wr_now(input logic [15:0] d, output int w);
    @(negedge clk);
    w = cyc + 1;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_at(input int tgt, input logic [15:0] d);
    @(negedge clk);
    while (cyc + 1 < tgt) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: start sampled run at select ps, stop after ncyc edges (R1, R2, R9)
  task automatic seg(input int ps, input int ncyc);
    int w, s, d;
    d = 1 << (ps + 1);
    mon_on = 1'b1;
    wr_now(16'h0300 | 16'(ps << 12), w);
    s = w + ncyc;
    for (int c = w + 1 + d; c <= s + 1; c += d) exp_q.push_back(c);
    wr_at(s, 16'h0100 | 16'(ps << 12));
    repeat (4) @(negedge clk);
    chk("R2 pending strobes after stop", exp_q.size(), 0);
    mon_on = 1'b0;
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int w, x, p, s, hits;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset rd_data", rd_data, 16'h0000);
    chk("R8 reset strobe", sample_strobe, 0);
    chk("R8 reset monitor_en", monitor_en, 0);

    // R6 field readback, R3 start lag
    wr_now(16'hFFFF, w);
    chk("R6 readback w", rd_data, 16'hF140);
    @(negedge clk); chk("R3 start lag w+1", rd_data, 16'hF140);
    @(negedge clk); chk("R3 status up w+2", rd_data, 16'hF340);
    // R3 stop lag, R2 stop
    wr_now(16'h0000, x);
    chk("R3 stop lag x", rd_data, 16'h0200);
    @(negedge clk); chk("R3 stop lag x+1", rd_data, 16'h0200);
    @(negedge clk); chk("R2 stopped x+2", rd_data, 16'h0000);

    // R4 continuous mode
    wr_now(16'h0200, w);
    chk("R4 cont not yet w", monitor_en, 0);
    @(negedge clk); chk("R4 cont not yet w+1", monitor_en, 0);
    @(negedge clk); chk("R4 cont on w+2", monitor_en, 1);
    @(negedge clk); chk("R4 cont on w+3", monitor_en, 1);

    // R5 standby gating
    standby = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R5 standby mon", monitor_en, 0);
      chk("R5 standby strobe", sample_strobe, 0);
      @(negedge clk);
    end
    wr_now(16'h0240, x);
    chk("R5 rsb mon", monitor_en, 1);
    hits = 0;
    for (int i = 0; i < 2; i++) begin
      if (sample_strobe) hits++;
      @(negedge clk);
    end
    chk("R5 rsb strobe count", hits, 1);
    standby = 1'b0;

    // R4 sampled mode, R1 period 4
    wr_now(16'h1300, w);
    repeat (3) @(negedge clk);
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      chk("R4 sampled mon==strobe", monitor_en, sample_strobe);
      if (sample_strobe) hits++;
      @(negedge clk);
    end
    chk("R1 strobes in 12 at div4", hits, 3);

    // R8 reset mid-run
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 mid reset rd_data", rd_data, 16'h0000);
    chk("R8 mid reset mon", monitor_en, 0);
    @(negedge clk);
    chk("R8 mid reset strobe", sample_strobe, 0);

    // R1, R2, R9 scoreboarded runs
    seg(0, 20);
    seg(2, 40);
    seg(4, 100);
    seg(7, 600);

    // R7 select change coinciding with a wrap
    mon_on = 1'b1;
    wr_now(16'h1300, w);
    exp_q.push_back(w + 5);
    p = w + 6;
    s = p + 40;
    for (int c = p + 7; c <= s + 1; c += 8) exp_q.push_back(c);
    wr_at(p, 16'h2300);
    wr_at(s, 16'h2100);
    repeat (4) @(negedge clk);
    chk("R7 pending after select change", exp_q.size(), 0);
    mon_on = 1'b0;

    // R1 largest division
    seg(15, 65600);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule